// File: doc/BRIEF.md
# Binary32 Reciprocal Estimate Unit

This unit takes one single-precision (binary32) operand and returns a low-precision estimate of its reciprocal as a binary32 value, together with IEEE exception flags. The estimate is bit-exact and fixed. It is not a real divide, and it is not an approximation with a loose error bound. Software uses it as the seed for Newton-Raphson refinement.

The operand is decoded and classified first. A subnormal operand is normalised with a leading-zero count. The top seven bits of the normalised fraction then index a 128-entry table of 7-bit values, and that value becomes the high part of the result fraction. The result exponent is computed arithmetically from the adjusted input exponent.

Infinities, zeros, NaNs, results that overflow and results that fall into the subnormal range all follow what `1.0/x` gives under IEEE 754. The result and the flags are registered once. An operand accepted in one cycle has its result available in the next cycle.

Top module: `frec_est`

## Requirements
- R1: While `rst_ni` is low, `valid_o`, `res_o` and `flags_o` are zero. After reset, `valid_o` is high in exactly the cycle after each cycle in which `valid_i` is high.
- R2: For a normal operand with biased exponent `e` between 1 and 252:
  - the result sign equals the operand sign;
  - the result biased exponent is `253 - e`;
  - the low 16 fraction bits are zero;
  - no flag is raised.
  Examples: 2.0 gives 0x3EFF0000, and -1.5 gives 0xBF2A0000.
- R3: Table entry `i` is round(128·(255−2i)/(257+2i)). Every normal-range result is within 2^-7 relative error of the true reciprocal, across all 128 table segments. An operand of 1.0 gives 0x3F7F0000.
- R4: An operand of +inf or -inf gives a zero of the same sign, with no flag raised.
- R5: An operand of +0 or -0 gives an infinity of the same sign. Only the divide-by-zero flag is raised.
- R6: Any NaN operand gives the canonical quiet NaN 0x7FC00000. The invalid flag is raised only when the operand is signalling, that is, when fraction bit 22 is clear.
- R7: A subnormal operand with fraction bit 22 or bit 21 set gives a normal result, computed from the operand normalised by its leading-zero count. Examples: 0x00400000 gives 0x7EFF0000, and 0x80200000 gives 0xFF7F0000.
- R8: A subnormal operand whose fraction is below 0x200000 overflows. It gives an infinity of the operand's sign and raises the overflow and inexact flags.
- R9: A normal operand with biased exponent 253 or 254 gives a subnormal result. The significand (leading 1, then the 7-bit table entry, then zeros) is shifted right by 1 for exponent 253 or by 2 for exponent 254, and no flag is raised. Examples: 0x7E800000 gives 0x007F8000, and 0xFF000000 gives 0x803FC000.
- R10: In a cycle with `valid_i` low, the operand is ignored and `res_o` and `flags_o` keep their previous values.

`flags_o` bit positions: bit 3 = invalid, bit 2 = divide-by-zero, bit 1 = overflow, bit 0 = inexact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand valid |
| op_i | input | 32 | Binary32 operand |
| valid_o | output | 1 | Result valid, one cycle after `valid_i` |
| res_o | output | 32 | Binary32 reciprocal estimate |
| flags_o | output | 4 | Flags: {invalid, divide-by-zero, overflow, inexact} |

## Verification
The bench sweeps all 128 table segments at three points in each: the lowest, the middle and the highest fraction. A wrong table entry, or an index taken from the wrong fraction bits, would push the relative error past 2^-7. Exact-value checks cover the operand 1.0, where an off-by-one in the exponent formula changes the result bits. They also cover the two largest subnormal bands, where a design that skips the leading-zero count would overflow, and exponents 253 and 254, where a missing denormalising shift would give a normal number or zero. The special-value checks separate quiet NaNs from signalling NaNs, and a design that flagged every NaN, or returned the input payload instead of the canonical NaN, would be caught there.

// File: rtl/frec_pkg.sv
package frec_pkg;
  typedef enum logic [2:0] {
    CL_ZERO, CL_SUB, CL_NORM, CL_INF, CL_QNAN, CL_SNAN
  } op_class_e;

  typedef struct packed {
    logic nv;
    logic dz;
    logic of;
    logic nx;
  } fflags_t;
endpackage

// File: rtl/frec_unpack.sv
module frec_unpack
  import frec_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int IDX_W  = 7,
  parameter int NEXP_W = EXP_W + 2
) (
  input  logic [EXP_W+FRAC_W:0]     op_i,
  output logic                      sign_o,
  output op_class_e                 cls_o,
  output logic signed [NEXP_W-1:0]  nexp_o,
  output logic [IDX_W-1:0]          idx_o
);
  localparam int LZ_W = $clog2(FRAC_W + 1);
  localparam int PAD  = FRAC_W - IDX_W;

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic [LZ_W-1:0]   lz;
  logic              found;

  assign sign_o = op_i[EXP_W+FRAC_W];
  assign exp_f  = op_i[FRAC_W +: EXP_W];
  assign frac_f = op_i[FRAC_W-1:0];

  // leading-zero count of the raw fraction
  always_comb begin
    lz    = '0;
    found = 1'b0;
    for (int k = FRAC_W - 1; k >= 0; k--) begin
      if (!found && frac_f[k]) found = 1'b1;
      else if (!found)         lz = lz + LZ_W'(1);
    end
  end

  always_comb begin
    if (&exp_f) begin
      if (frac_f == '0)            cls_o = CL_INF;
      else if (frac_f[FRAC_W-1])   cls_o = CL_QNAN;
      else                         cls_o = CL_SNAN;
    end else if (exp_f == '0) begin
      cls_o = (frac_f == '0) ? CL_ZERO : CL_SUB;
    end else begin
      cls_o = CL_NORM;
    end
  end

  always_comb begin
    if (exp_f == '0) begin
      nexp_o = -$signed({{(NEXP_W-LZ_W){1'b0}}, lz});
      idx_o  = IDX_W'(FRAC_W'((frac_f << lz) << 1) >> PAD);
    end else begin
      nexp_o = $signed({{(NEXP_W-EXP_W){1'b0}}, exp_f});
      idx_o  = frac_f[FRAC_W-1 -: IDX_W];
    end
  end
endmodule

// File: rtl/frec_lut.sv
module frec_lut #(
  parameter int IDX_W = 7
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [IDX_W-1:0] ent_o
);
  localparam int N = 1 << IDX_W;

  // midpoint reciprocal of each segment, rounded to IDX_W bits
  function automatic logic [IDX_W-1:0] ent_f(input int i);
    int num, den, q;
    num = (1 << IDX_W) * ((1 << (IDX_W + 1)) - 1 - 2 * i);
    den = (1 << (IDX_W + 1)) + 1 + 2 * i;
    q   = (2 * num + den) / (2 * den);
    if (q > N - 1) q = N - 1;
    return q[IDX_W-1:0];
  endfunction

  logic [IDX_W-1:0] rom [N];

  for (genvar g = 0; g < N; g++) begin : g_rom
    assign rom[g] = ent_f(g);
  end

  assign ent_o = rom[idx_i];
endmodule

// File: rtl/frec_pack.sv
module frec_pack
  import frec_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int IDX_W  = 7,
  parameter int NEXP_W = EXP_W + 2
) (
  input  logic                     sign_i,
  input  op_class_e                cls_i,
  input  logic signed [NEXP_W-1:0] nexp_i,
  input  logic [IDX_W-1:0]         ent_i,
  output logic [EXP_W+FRAC_W:0]    res_o,
  output fflags_t                  flags_o
);
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam int EMAX = (1 << EXP_W) - 1;
  localparam int PAD  = FRAC_W - IDX_W;

  logic signed [NEXP_W-1:0] oexp;
  logic [FRAC_W:0]          full_sig;
  logic [FRAC_W-1:0]        den_sig;

  assign oexp     = $signed(NEXP_W'(2 * BIAS - 1)) - nexp_i;
  assign full_sig = {1'b1, ent_i, {PAD{1'b0}}};
  // oexp is 0 or -1 on the subnormal path
  assign den_sig  = (oexp == '0) ? FRAC_W'(full_sig >> 1) : FRAC_W'(full_sig >> 2);

  always_comb begin
    flags_o = '0;
    res_o   = '0;
    unique case (cls_i)
      CL_ZERO: begin
        res_o      = {sign_i, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        flags_o.dz = 1'b1;
      end
      CL_INF:  res_o = {sign_i, {(EXP_W+FRAC_W){1'b0}}};
      CL_QNAN, CL_SNAN: begin
        res_o      = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
        flags_o.nv = (cls_i == CL_SNAN);
      end
      default: begin
        if (oexp >= $signed(NEXP_W'(EMAX))) begin
          res_o      = {sign_i, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
          flags_o.of = 1'b1;
          flags_o.nx = 1'b1;
        end else if (oexp > 0) begin
          res_o = {sign_i, oexp[EXP_W-1:0], ent_i, {PAD{1'b0}}};
        end else begin
          res_o = {sign_i, {EXP_W{1'b0}}, den_sig};
        end
      end
    endcase
  end
endmodule

// File: rtl/frec_est.sv
module frec_est
  import frec_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int IDX_W  = 7
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic [EXP_W+FRAC_W:0]   op_i,
  output logic                    valid_o,
  output logic [EXP_W+FRAC_W:0]   res_o,
  output logic [3:0]              flags_o
);
  localparam int W      = 1 + EXP_W + FRAC_W;
  localparam int NEXP_W = EXP_W + 2;
  localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic                     sign;
  op_class_e                cls;
  logic signed [NEXP_W-1:0] nexp;
  logic [IDX_W-1:0]         idx;
  logic [IDX_W-1:0]         ent;
  logic [W-1:0]             res_d;
  fflags_t                  flags_d;

  frec_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .IDX_W(IDX_W), .NEXP_W(NEXP_W)) u_unpack (
    .op_i   (op_i),
    .sign_o (sign),
    .cls_o  (cls),
    .nexp_o (nexp),
    .idx_o  (idx)
  );

  frec_lut #(.IDX_W(IDX_W)) u_lut (
    .idx_i (idx),
    .ent_o (ent)
  );

  frec_pack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .IDX_W(IDX_W), .NEXP_W(NEXP_W)) u_pack (
    .sign_i  (sign),
    .cls_i   (cls),
    .nexp_i  (nexp),
    .ent_i   (ent),
    .res_o   (res_d),
    .flags_o (flags_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      res_o   <= '0;
      flags_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        res_o   <= res_d;
        flags_o <= flags_d;
      end
    end
  end

  logic             op_nan, op_inf, op_zero, op_tiny;
  logic [EXP_W-1:0] op_exp;
  assign op_exp  = op_i[FRAC_W +: EXP_W];
  assign op_nan  = (&op_exp) && (op_i[FRAC_W-1:0] != '0);
  assign op_inf  = (&op_exp) && (op_i[FRAC_W-1:0] == '0);
  assign op_zero = (op_exp == '0) && (op_i[FRAC_W-1:0] == '0);
  assign op_tiny = (op_exp == '0) && (op_i[FRAC_W-1:0] != '0) && (op_i[FRAC_W-1:FRAC_W-2] == 2'b00);

  p_latency_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i));

  p_sign_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !op_nan |=> res_o[W-1] == $past(op_i[W-1]));

  p_inf_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_inf |=> res_o[W-2:0] == '0 && flags_o == 4'b0000);

  p_zero_dz_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_zero |=> res_o[W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}} && flags_o == 4'b0100);

  p_nan_canon_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_nan |=> res_o == QNAN && flags_o[2:0] == 3'b000);

  p_sub_ovf_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_tiny |=> res_o[W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}} && flags_o == 4'b0011);

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(res_o) && $stable(flags_o));
endmodule

// File: tb/tb_frec_est.sv
`timescale 1ns/1ps
module tb_frec_est;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] op_i = '0;
  logic        valid_o;
  logic [31:0] res_o;
  logic [3:0]  flags_o;

  frec_est dut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .valid_i (valid_i),
    .op_i    (op_i),
    .valid_o (valid_o),
    .res_o   (res_o),
    .flags_o (flags_o)
  );

  always #2 clk = ~clk;

  typedef struct packed {
    logic [31:0] op;
    logic [31:0] res;
    logic [3:0]  fl;
    logic        approx;
    logic [31:0] cyc;
    logic [23:0] req;
  } item_t;

  item_t       sbq[$];
  int          n_tests = 0;
  int          n_fail  = 0;
  int          cyc     = 0;
  bit          done    = 1'b0;
  logic [31:0] last_res = '0;
  logic [3:0]  last_fl  = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] op, input logic [31:0] r, input logic [3:0] f,
                      input bit ap, input logic [23:0] req);
    item_t it;
    it.op = op; it.res = r; it.fl = f; it.approx = ap;
    it.cyc = 32'(cyc + 1); it.req = req;
    sbq.push_back(it);
    if (!ap) begin last_res = r; last_fl = f; end
    op_i    = op;
    valid_i = 1'b1;
    @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin : mon
    item_t it;
    real   p, rel;
    int    ei, eo;
    if (rst_n && valid_o) begin
      if (sbq.size() == 0) begin
        chk(1'b0, "R1", 32'(valid_o), 32'd0);
      end else begin
        it = sbq.pop_front();
        chk(32'(cyc) == it.cyc, "R1", 32'(cyc), it.cyc);
        if (it.approx) begin
          ei = int'(it.op[30:23]);
          eo = int'(res_o[30:23]);
          chk(res_o[31] == it.op[31] && eo == 253 - ei && res_o[15:0] == 16'h0 && flags_o == 4'h0,
              "R2", res_o, {it.op[31], 8'(253 - ei), 23'h0});
          p   = (1.0 + real'(res_o[22:0]) / 8388608.0) * (1.0 + real'(it.op[22:0]) / 8388608.0) / 2.0;
          rel = (p > 1.0) ? p - 1.0 : 1.0 - p;
          n_tests++;
          if (!(rel < 0.0078125)) begin
            n_fail++;
            $display("FAIL R3: op %h actual %h rel err %f expected < %f", it.op, res_o, rel, 0.0078125);
          end
        end else begin
          chk(res_o == it.res, $sformatf("%s", it.req), res_o, it.res);
          chk(flags_o == it.fl, $sformatf("%s flags", it.req), 32'(flags_o), 32'(it.fl));
        end
      end
    end
  end

  task automatic idle_chk();
    valid_i = 1'b0;
    op_i    = 32'h0000_0000;   // a zero would raise divide-by-zero if taken
    repeat (3) @(negedge clk);
    chk(valid_o == 1'b0, "R10", 32'(valid_o), 32'd0);
    chk(res_o == last_res, "R10", res_o, last_res);
    chk(flags_o == last_fl, "R10 flags", 32'(flags_o), 32'(last_fl));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL R1 watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    chk(valid_o == 1'b0 && res_o == 32'h0 && flags_o == 4'h0, "R1 reset", res_o, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    push(32'h3F80_0000, 32'h3F7F_0000, 4'h0, 1'b0, "R3");
    push(32'h4000_0000, 32'h3EFF_0000, 4'h0, 1'b0, "R2");
    push(32'hBFC0_0000, 32'hBF2A_0000, 4'h0, 1'b0, "R2");
    push(32'h7F80_0000, 32'h0000_0000, 4'h0, 1'b0, "R4");
    push(32'hFF80_0000, 32'h8000_0000, 4'h0, 1'b0, "R4");
    push(32'h0000_0000, 32'h7F80_0000, 4'h4, 1'b0, "R5");
    push(32'h8000_0000, 32'hFF80_0000, 4'h4, 1'b0, "R5");
    push(32'h7FC0_0001, 32'h7FC0_0000, 4'h0, 1'b0, "R6");
    push(32'hFF80_0001, 32'h7FC0_0000, 4'h8, 1'b0, "R6");
    push(32'h0040_0000, 32'h7EFF_0000, 4'h0, 1'b0, "R7");
    push(32'h8020_0000, 32'hFF7F_0000, 4'h0, 1'b0, "R7");
    push(32'h001F_FFFF, 32'h7F80_0000, 4'h3, 1'b0, "R8");
    push(32'h8000_0001, 32'hFF80_0000, 4'h3, 1'b0, "R8");
    push(32'h7E80_0000, 32'h007F_8000, 4'h0, 1'b0, "R9");
    push(32'hFF00_0000, 32'h803F_C000, 4'h0, 1'b0, "R9");
    idle_chk();

    push(32'h7FA0_0000, 32'h7FC0_0000, 4'h8, 1'b0, "R6");
    idle_chk();

    // sweep every table segment at low, high and middle fraction
    for (int i = 0; i < 128; i++) begin
      for (int k = 0; k < 3; k++) begin
        logic [15:0] low;
        int          ei;
        low = (k == 0) ? 16'h0000 : (k == 1) ? 16'hFFFF : 16'h8000;
        ei  = 1 + ((i * 37 + k * 11) % 252);
        push({i[0], 8'(ei), 7'(i), low}, 32'h0, 4'h0, 1'b1, "R3");
      end
    end
    valid_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(sbq.size() == 0, "R1 drain", 32'(sbq.size()), 32'd0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule